// File: doc/BRIEF.md
# Counter-Mode Memory Pad Controller

This block sits between the last-level cache's miss and writeback requests and a block-cipher port that works by request and response. Every 64-byte memory block gets a seed made from its block address and a per-block write counter. The cipher turns that seed into four 128-bit keystream words, and those words are XORed with the ciphertext fetched from memory on a read, or with the plaintext leaving for memory on a writeback.

Per-block counters are kept in a small direct-mapped store on chip. A hit in the store lets the pad requests go out in the same cycle as the data fetch, so the cipher latency hides under the memory latency. A miss first writes back any valid victim counter and then reads the counter from a dedicated counter-memory port. No pad request leaves before that counter returns.

Each writeback raises the block's counter before its pads are requested, so no seed is ever used twice. A counter that is already at its maximum is not allowed to wrap: the writeback is refused and an error pulse is raised instead.

Top module: `ctr_pad_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rd_valid`, `wb_valid`, `err_ovf`, `ciph_req_valid`, `mem_rd_req` and `cm_req_valid` are all 0.
- R2: The seed for pad word k (k = 0..3) has the word index k in bits [1:0], the block's counter in bits [CTR_W+1:2] and the block address in the next ADDR_W bits, with all higher bits zero. The four seeds of one operation are requested in the order k = 0, 1, 2, 3.
- R3: A writeback first adds one to the block's counter and uses the new value in its seeds. The new value stays in the store, and it is the value written out when the entry is later evicted.
- R4: Pad word k is XORed with bits [128k+127:128k] of the block. `rd_data` is the fetched ciphertext XOR pads, and `wb_data` is the request's plaintext XOR pads.
- R5: On a counter-store hit there is no counter-memory traffic, and the data fetch (`mem_rd_req`) is issued in the same cycle as the first pad request.
- R6: On a counter-store miss, a counter read is issued on the counter port. No pad request is made until the cycle after the counter response, and the seeds use the returned counter.
- R7: A read result (`rd_valid`) is raised in the cycle right after the cycle in which the later of the ciphertext block and the fourth pad word arrives.
- R8: A writeback whose counter is already all ones raises `err_ovf` for one cycle. It requests no pads, gives no `wb_valid`, and leaves the counter unchanged.
- R9: The counter store is direct mapped on the low log2(SETS) address bits and holds valid bits, so every entry misses after reset. A miss on a valid entry that holds another address first writes that entry's counter to the counter port at the victim's address, and only then issues the fill read.
- R10: One operation is handled at a time. `req_ready` is 0 from the cycle after acceptance until the cycle after the result, and each operation ends with exactly one of `rd_valid`, `wb_valid` or `err_ovf` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request from cache; taken when req_ready is 1 |
| req_write | input | 1 | 1 for writeback, 0 for read miss |
| req_addr | input | ADDR_W | Block address |
| req_wdata | input | 512 | Writeback plaintext |
| req_ready | output | 1 | Idle and able to take a request |
| mem_rd_req | output | 1 | One-cycle data fetch request |
| mem_rd_addr | output | ADDR_W | Fetch block address |
| mem_rd_rvalid | input | 1 | Ciphertext block returned |
| mem_rd_rdata | input | 512 | Ciphertext block |
| ciph_req_valid | output | 1 | Seed request to cipher |
| ciph_req_ready | input | 1 | Cipher takes the seed |
| ciph_req_seed | output | 128 | Seed |
| ciph_rsp_valid | input | 1 | Pad word returned (in request order) |
| ciph_rsp_pad | input | 128 | Pad word |
| cm_req_valid | output | 1 | One-cycle counter-memory request |
| cm_req_write | output | 1 | 1 for victim write, 0 for fill read |
| cm_req_addr | output | ADDR_W | Block address of the counter |
| cm_req_wdata | output | CTR_W | Victim counter |
| cm_rsp_valid | input | 1 | Fill counter returned |
| cm_rsp_data | input | CTR_W | Fill counter |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 512 | Decrypted block |
| wb_valid | output | 1 | Encrypted writeback valid |
| wb_addr | output | ADDR_W | Writeback block address |
| wb_data | output | 512 | Encrypted block |
| err_ovf | output | 1 | Writeback refused on counter overflow |

## Verification
Each result has a known due time. A read result is due exactly one cycle after the later of the ciphertext and the fourth pad word, and the bench's memory and cipher models log the cycle of every arrival so that this can be compared cycle for cycle. The latencies are set so that data arrives last in one test and the pads arrive last in another. The models also log the cycle of the first pad request, the data fetch, the counter response, and the victim write and fill read, so that overlap on a hit and ordering on a miss are checked as cycle relations rather than by waiting. All models drive and sample on the falling edge, and the design's registered outputs are read there too, well away from the capturing edge.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;
  localparam int WORD_W = 128;
  localparam int WORDS  = 4;
  localparam int BLK_W  = WORD_W * WORDS;
  localparam int SEED_W = 128;

  typedef enum logic [3:0] {
    PS_IDLE, PS_LOOK, PS_EVICT, PS_FILL_REQ, PS_FILL_WAIT,
    PS_BUMP, PS_PADS, PS_DONE, PS_OVF
  } pad_state_e;

  // word index low, counter above it, block address above that
  function automatic logic [SEED_W-1:0] make_seed(input logic [63:0] addr,
                                                  input logic [31:0] ctr,
                                                  input logic [1:0]  widx,
                                                  input int unsigned ctr_w);
    logic [SEED_W-1:0] s;
    s = SEED_W'(widx);
    s = s | (SEED_W'(ctr) << 2);
    s = s | (SEED_W'(addr) << (2 + ctr_w));
    return s;
  endfunction

  function automatic logic [BLK_W-1:0] apply_pad(input logic [BLK_W-1:0] blk,
                                                 input logic [BLK_W-1:0] pad);
    return blk ^ pad;
  endfunction
endpackage

// File: rtl/cmpc_ctr_store.sv
module cmpc_ctr_store #(
  parameter int ADDR_W = 26,
  parameter int CTR_W  = 8,
  parameter int SETS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic              wr_en,
  input  logic [CTR_W-1:0]  wr_ctr,
  output logic              hit,
  output logic              vic_valid,
  output logic [ADDR_W-1:0] vic_addr,
  output logic [CTR_W-1:0]  slot_ctr
);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS];
  logic [CTR_W-1:0] ctr_q [SETS];

  assign idx = look_addr[IDX_W-1:0];
  assign tag = look_addr[ADDR_W-1:IDX_W];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic sel;
    assign sel = wr_en && (idx == IDX_W'(s));
    always_ff @(posedge clk) begin
      if (!rst_n)   vld_q[s] <= 1'b0;
      else if (sel) vld_q[s] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[s] <= tag;
        ctr_q[s] <= wr_ctr;
      end
    end
  end

  assign vic_valid = vld_q[idx];
  assign hit       = vld_q[idx] && (tag_q[idx] == tag);
  assign vic_addr  = {tag_q[idx], idx};
  assign slot_ctr  = ctr_q[idx];
endmodule

// File: rtl/cmpc_pad_collect.sv
module cmpc_pad_collect
  import cmpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              pad_valid,
  input  logic [WORD_W-1:0] pad_word,
  input  logic              data_valid,
  input  logic [BLK_W-1:0]  data_in,
  input  logic              need_data,
  output logic              pads_full,
  output logic              finish,
  output logic [BLK_W-1:0]  pad_blk,
  output logic [BLK_W-1:0]  data_blk
);
  logic [2:0] pcnt_q;
  logic       have_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pcnt_q      <= '0;
      have_data_q <= 1'b0;
      pad_blk     <= '0;
      data_blk    <= '0;
    end else begin
      if (pad_valid && !pads_full) begin
        pad_blk[pcnt_q[1:0]*WORD_W +: WORD_W] <= pad_word;
        pcnt_q <= pcnt_q + 3'd1;
      end
      if (data_valid) begin
        data_blk    <= data_in;
        have_data_q <= 1'b1;
      end
    end
  end

  assign pads_full = (pcnt_q == 3'(WORDS));
  // goes high in the cycle the last missing piece arrives
  assign finish = (pads_full || (pad_valid && pcnt_q == 3'(WORDS - 1))) &&
                  (!need_data || have_data_q || data_valid);
endmodule

// File: rtl/ctr_pad_ctrl.sv
module ctr_pad_ctrl
  import cmpc_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int CTR_W  = 8,
  parameter int SETS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [511:0]      req_wdata,
  output logic              req_ready,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_rvalid,
  input  logic [511:0]      mem_rd_rdata,
  output logic              ciph_req_valid,
  input  logic              ciph_req_ready,
  output logic [127:0]      ciph_req_seed,
  input  logic              ciph_rsp_valid,
  input  logic [127:0]      ciph_rsp_pad,
  output logic              cm_req_valid,
  output logic              cm_req_write,
  output logic [ADDR_W-1:0] cm_req_addr,
  output logic [CTR_W-1:0]  cm_req_wdata,
  input  logic              cm_rsp_valid,
  input  logic [CTR_W-1:0]  cm_rsp_data,
  output logic              rd_valid,
  output logic [511:0]      rd_data,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [511:0]      wb_data,
  output logic              err_ovf
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  pad_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [BLK_W-1:0]  wdata_q;
  logic [2:0]        sent_q;
  logic              fetch_sent_q;

  logic              hit, vic_valid;
  logic [ADDR_W-1:0] vic_addr;
  logic [CTR_W-1:0]  slot_ctr;
  logic              st_wr_en;
  logic [CTR_W-1:0]  st_wr_ctr;

  logic              accept, finish, pads_full;
  logic [BLK_W-1:0]  pad_blk, data_blk;

  // named events for the checker
  logic              ctr_wait;
  logic              pad_fire;

  assign accept   = (state_q == PS_IDLE) && req_valid;
  assign ctr_wait = (state_q == PS_EVICT) || (state_q == PS_FILL_REQ) ||
                    (state_q == PS_FILL_WAIT);
  assign pad_fire = ciph_req_valid && ciph_req_ready;

  cmpc_ctr_store #(.ADDR_W(ADDR_W), .CTR_W(CTR_W), .SETS(SETS)) u_store (
    .clk(clk), .rst_n(rst_n), .look_addr(addr_q),
    .wr_en(st_wr_en), .wr_ctr(st_wr_ctr),
    .hit(hit), .vic_valid(vic_valid), .vic_addr(vic_addr), .slot_ctr(slot_ctr)
  );

  cmpc_pad_collect u_collect (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .pad_valid(ciph_rsp_valid), .pad_word(ciph_rsp_pad),
    .data_valid(mem_rd_rvalid), .data_in(mem_rd_rdata), .need_data(!wr_q),
    .pads_full(pads_full), .finish(finish),
    .pad_blk(pad_blk), .data_blk(data_blk)
  );

  always_comb begin
    state_d   = state_q;
    st_wr_en  = 1'b0;
    st_wr_ctr = slot_ctr;
    unique case (state_q)
      PS_IDLE:      if (req_valid) state_d = PS_LOOK;
      PS_LOOK: begin
        if (hit)            state_d = wr_q ? PS_BUMP : PS_PADS;
        else if (vic_valid) state_d = PS_EVICT;
        else                state_d = PS_FILL_REQ;
      end
      PS_EVICT:     state_d = PS_FILL_REQ;
      PS_FILL_REQ:  state_d = PS_FILL_WAIT;
      PS_FILL_WAIT: begin
        if (cm_rsp_valid) begin
          st_wr_en  = 1'b1;
          st_wr_ctr = cm_rsp_data;
          state_d   = wr_q ? PS_BUMP : PS_PADS;
        end
      end
      PS_BUMP: begin
        if (slot_ctr == CTR_MAX) state_d = PS_OVF;
        else begin
          st_wr_en  = 1'b1;
          st_wr_ctr = slot_ctr + 1'b1;
          state_d   = PS_PADS;
        end
      end
      PS_PADS:      if (finish) state_d = PS_DONE;
      PS_DONE:      state_d = PS_IDLE;
      PS_OVF:       state_d = PS_IDLE;
      default:      state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= PS_IDLE;
      addr_q       <= '0;
      wr_q         <= 1'b0;
      wdata_q      <= '0;
      sent_q       <= '0;
      fetch_sent_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q       <= req_addr;
        wr_q         <= req_write;
        wdata_q      <= req_wdata;
        sent_q       <= '0;
        fetch_sent_q <= 1'b0;
      end else begin
        if (pad_fire)   sent_q       <= sent_q + 3'd1;
        if (mem_rd_req) fetch_sent_q <= 1'b1;
      end
    end
  end

  assign req_ready      = (state_q == PS_IDLE);
  assign ciph_req_valid = (state_q == PS_PADS) && (sent_q != 3'(WORDS));
  assign ciph_req_seed  = make_seed(64'(addr_q), 32'(slot_ctr), sent_q[1:0], CTR_W);
  assign mem_rd_req     = (state_q == PS_PADS) && !wr_q && !fetch_sent_q;
  assign mem_rd_addr    = addr_q;
  assign cm_req_valid   = (state_q == PS_EVICT) || (state_q == PS_FILL_REQ);
  assign cm_req_write   = (state_q == PS_EVICT);
  assign cm_req_addr    = (state_q == PS_EVICT) ? vic_addr : addr_q;
  assign cm_req_wdata   = slot_ctr;
  assign rd_valid       = (state_q == PS_DONE) && !wr_q;
  assign rd_data        = apply_pad(data_blk, pad_blk);
  assign wb_valid       = (state_q == PS_DONE) && wr_q;
  assign wb_addr        = addr_q;
  assign wb_data        = apply_pad(wdata_q, pad_blk);
  assign err_ovf        = (state_q == PS_OVF);
endmodule

// File: rtl/cmpc_checker.sv
module cmpc_checker (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rd_valid,
  input logic wb_valid,
  input logic err_ovf,
  input logic ciph_req_valid,
  input logic mem_rd_req,
  input logic ctr_wait,
  input logic pads_full
);
  a_r6_no_pad_during_ctr_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_wait |-> !ciph_req_valid);

  a_r7_release_needs_pads: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> pads_full);

  a_r8_refused_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |-> !wb_valid && !ciph_req_valid);

  a_r10_single_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, wb_valid, err_ovf}));

  a_r10_busy_at_result: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wb_valid || err_ovf) |-> !req_ready);

  a_r10_ready_after_result: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wb_valid || err_ovf) |=> req_ready);

  a_r5_fetch_with_pad: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> ciph_req_valid);
endmodule

bind ctr_pad_ctrl cmpc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .wb_valid(wb_valid), .err_ovf(err_ovf), .ciph_req_valid(ciph_req_valid),
  .mem_rd_req(mem_rd_req), .ctr_wait(ctr_wait), .pads_full(pads_full)
);

// File: tb/ctr_pad_ctrl_tb_top.sv
module ctr_pad_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 26;
  localparam int CTR_W  = 8;
  localparam int SETS   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [511:0] req_wdata = '0;
  logic req_ready;
  logic mem_rd_req;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic mem_rd_rvalid = 1'b0;
  logic [511:0] mem_rd_rdata = '0;
  logic ciph_req_valid;
  logic ciph_req_ready = 1'b1;
  logic [127:0] ciph_req_seed;
  logic ciph_rsp_valid = 1'b0;
  logic [127:0] ciph_rsp_pad = '0;
  logic cm_req_valid, cm_req_write;
  logic [ADDR_W-1:0] cm_req_addr;
  logic [CTR_W-1:0] cm_req_wdata;
  logic cm_rsp_valid = 1'b0;
  logic [CTR_W-1:0] cm_rsp_data = '0;
  logic rd_valid, wb_valid, err_ovf;
  logic [511:0] rd_data, wb_data;
  logic [ADDR_W-1:0] wb_addr;

  ctr_pad_ctrl #(.ADDR_W(ADDR_W), .CTR_W(CTR_W), .SETS(SETS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_rdata(mem_rd_rdata),
    .ciph_req_valid(ciph_req_valid), .ciph_req_ready(ciph_req_ready),
    .ciph_req_seed(ciph_req_seed), .ciph_rsp_valid(ciph_rsp_valid),
    .ciph_rsp_pad(ciph_rsp_pad), .cm_req_valid(cm_req_valid),
    .cm_req_write(cm_req_write), .cm_req_addr(cm_req_addr),
    .cm_req_wdata(cm_req_wdata), .cm_rsp_valid(cm_rsp_valid),
    .cm_rsp_data(cm_rsp_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .err_ovf(err_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  // ---------------- reference functions ----------------
  function automatic logic [127:0] tb_seed(input logic [ADDR_W-1:0] a,
                                           input logic [CTR_W-1:0] c,
                                           input logic [1:0] k);
    return {{(128-ADDR_W-CTR_W-2){1'b0}}, a, c, k};
  endfunction

  function automatic logic [127:0] tb_pad(input logic [127:0] s);
    return {s[63:0] ^ 64'h5A5A_1234_9ABC_DEF0, ~s[63:0] ^ 64'h0F0F_3C3C_A5A5_7E7E};
  endfunction

  function automatic logic [511:0] tb_pads(input logic [ADDR_W-1:0] a,
                                           input logic [CTR_W-1:0] c);
    logic [511:0] b;
    for (int k = 0; k < 4; k++) b[k*128 +: 128] = tb_pad(tb_seed(a, c, 2'(k)));
    return b;
  endfunction

  function automatic logic [511:0] tb_ct(input logic [ADDR_W-1:0] a);
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[i*32 +: 32] = 32'(a) * 32'h9E37_79B1 + 32'(i * 7 + 1);
    return b;
  endfunction

  // ---------------- models (drive and sample on falling edge) ----------------
  int ciph_lat = 4, mem_lat = 6, cm_lat = 3;
  logic [127:0] q_seed [0:15];
  int q_t [0:15];
  int q_wr = 0, q_rd = 0;
  logic [127:0] seen_seed [0:3];
  int n_seed, first_pad_cyc, last_pad_cyc;
  int mem_due = -1;
  logic [ADDR_W-1:0] mem_a;
  int fetch_cyc, data_cyc;
  int cm_due = -1;
  logic [ADDR_W-1:0] cm_a;
  int cm_rsp_cyc, cm_reads, cm_writes, cmw_cyc, cmr_cyc;
  logic [ADDR_W-1:0] last_cmw_addr;
  logic [CTR_W-1:0] last_cmw_data;
  logic [CTR_W-1:0] ctr_mem [0:255];

  always @(negedge clk) begin
    ciph_rsp_valid = 1'b0;
    mem_rd_rvalid  = 1'b0;
    cm_rsp_valid   = 1'b0;
    if (rst_n) begin
      if (ciph_req_valid && ciph_req_ready) begin
        q_seed[q_wr % 16] = ciph_req_seed;
        q_t[q_wr % 16] = cyc;
        q_wr++;
        if (n_seed < 4) seen_seed[n_seed] = ciph_req_seed;
        n_seed++;
        if (first_pad_cyc < 0) first_pad_cyc = cyc;
      end
      if (q_rd < q_wr && cyc >= q_t[q_rd % 16] + ciph_lat) begin
        ciph_rsp_valid = 1'b1;
        ciph_rsp_pad = tb_pad(q_seed[q_rd % 16]);
        q_rd++;
        last_pad_cyc = cyc;
      end
      if (mem_rd_req) begin
        mem_due = cyc + mem_lat;
        mem_a = mem_rd_addr;
        fetch_cyc = cyc;
      end
      if (mem_due >= 0 && cyc == mem_due) begin
        mem_rd_rvalid = 1'b1;
        mem_rd_rdata = tb_ct(mem_a);
        mem_due = -1;
        data_cyc = cyc;
      end
      if (cm_req_valid) begin
        if (cm_req_write) begin
          ctr_mem[cm_req_addr[7:0]] = cm_req_wdata;
          cm_writes++;
          last_cmw_addr = cm_req_addr;
          last_cmw_data = cm_req_wdata;
          cmw_cyc = cyc;
        end else begin
          cm_due = cyc + cm_lat;
          cm_a = cm_req_addr;
          cm_reads++;
          cmr_cyc = cyc;
        end
      end
      if (cm_due >= 0 && cyc == cm_due) begin
        cm_rsp_valid = 1'b1;
        cm_rsp_data = ctr_mem[cm_a[7:0]];
        cm_due = -1;
        cm_rsp_cyc = cyc;
      end
    end
  end

  // ---------------- check helpers ----------------
  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int res_kind, res_cyc, busy_viol;
  logic [511:0] res_data;
  logic [ADDR_W-1:0] res_addr;

  task automatic run_op(input bit wr, input logic [ADDR_W-1:0] a, input logic [511:0] wd);
    @(negedge clk);
    n_seed = 0; first_pad_cyc = -1; last_pad_cyc = -1; fetch_cyc = -1; data_cyc = -1;
    cm_reads = 0; cm_writes = 0; cm_rsp_cyc = -1; cmw_cyc = -1; cmr_cyc = -1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    res_kind = -1; busy_viol = 0;
    for (int i = 0; i < 2000; i++) begin
      if (rd_valid || wb_valid || err_ovf) begin
        res_kind = rd_valid ? 0 : (wb_valid ? 1 : 2);
        res_data = rd_valid ? rd_data : wb_data;
        res_addr = wb_addr;
        res_cyc = cyc;
        break;
      end
      if (req_ready) busy_viol++;
      @(negedge clk);
    end
    chk("R10 operation completed", 512'(res_kind >= 0), 512'(1));
    chk("R10 busy while in flight", 512'(busy_viol), 512'(0));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk("R1 req_ready", 512'(req_ready), 512'(1));
    chk("R1 outputs idle", 512'({rd_valid, wb_valid, err_ovf, ciph_req_valid,
                                 mem_rd_req, cm_req_valid}), 512'(0));
  endtask

  task automatic t_read_cold_miss;
    ciph_lat = 4; mem_lat = 6; cm_lat = 3;
    run_op(1'b0, 26'h10, '0);
    chk("R9 cold miss one fill read", 512'(cm_reads), 512'(1));
    chk("R9 cold miss no victim write", 512'(cm_writes), 512'(0));
    chk("R6 pad after counter", 512'(first_pad_cyc > cm_rsp_cyc), 512'(1));
    for (int k = 0; k < 4; k++)
      chk("R2 seed layout", seen_seed[k], tb_seed(26'h10, 8'd5, 2'(k)));
    chk("R4 read kind", 512'(res_kind), 512'(0));
    chk("R4 read decrypt", res_data, tb_ct(26'h10) ^ tb_pads(26'h10, 8'd5));
  endtask

  task automatic t_read_hit_data_last;
    ciph_lat = 3; mem_lat = 20;
    run_op(1'b0, 26'h10, '0);
    chk("R5 hit no counter traffic", 512'(cm_reads + cm_writes), 512'(0));
    chk("R5 fetch with first pad", 512'(fetch_cyc), 512'(first_pad_cyc));
    chk("R7 data last timing", 512'(res_cyc), 512'(data_cyc + 1));
    chk("R4 hit decrypt", res_data, tb_ct(26'h10) ^ tb_pads(26'h10, 8'd5));
  endtask

  task automatic t_read_hit_pads_last;
    ciph_lat = 12; mem_lat = 2;
    run_op(1'b0, 26'h10, '0);
    chk("R7 pads last timing", 512'(res_cyc), 512'(last_pad_cyc + 1));
    chk("R4 pads-last decrypt", res_data, tb_ct(26'h10) ^ tb_pads(26'h10, 8'd5));
  endtask

  task automatic t_write_hit;
    logic [511:0] wd;
    wd = {16{32'hC0DE_0000}} ^ tb_ct(26'h3);
    ciph_lat = 4;
    run_op(1'b1, 26'h10, wd);
    chk("R3 write kind", 512'(res_kind), 512'(1));
    chk("R3 bumped seed", seen_seed[0], tb_seed(26'h10, 8'd6, 2'd0));
    chk("R4 wb address", 512'(res_addr), 512'(26'h10));
    chk("R4 wb encrypt", res_data, wd ^ tb_pads(26'h10, 8'd6));
    run_op(1'b0, 26'h10, '0);
    chk("R3 stored counter used", res_data, tb_ct(26'h10) ^ tb_pads(26'h10, 8'd6));
  endtask

  task automatic t_evict;
    run_op(1'b0, 26'h14, '0);
    chk("R9 victim write", 512'(cm_writes), 512'(1));
    chk("R9 victim address", 512'(last_cmw_addr), 512'(26'h10));
    chk("R3 victim counter", 512'(last_cmw_data), 512'(6));
    chk("R9 write before fill", 512'(cmw_cyc < cmr_cyc), 512'(1));
    chk("R6 miss counter used", res_data, tb_ct(26'h14) ^ tb_pads(26'h14, 8'd9));
  endtask

  task automatic t_overflow;
    run_op(1'b1, 26'h21, {16{32'h1111_2222}});
    chk("R8 error result", 512'(res_kind), 512'(2));
    chk("R8 no pads requested", 512'(n_seed), 512'(0));
    run_op(1'b0, 26'h21, '0);
    chk("R8 counter unchanged", res_data, tb_ct(26'h21) ^ tb_pads(26'h21, 8'hFF));
  endtask

  task automatic t_write_miss;
    logic [511:0] wd;
    wd = tb_ct(26'h77);
    run_op(1'b1, 26'h22, wd);
    chk("R6 write miss fill", 512'(cm_reads), 512'(1));
    chk("R3 write miss encrypt", res_data, wd ^ tb_pads(26'h22, 8'd1));
    run_op(1'b0, 26'h26, '0);
    chk("R3 evicted bumped counter", 512'(last_cmw_data), 512'(1));
    chk("R9 evicted address", 512'(last_cmw_addr), 512'(26'h22));
    chk("R4 read after evict", res_data, tb_ct(26'h26) ^ tb_pads(26'h26, 8'd3));
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired R10");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) ctr_mem[i] = '0;
    ctr_mem[8'h10] = 8'd5;
    ctr_mem[8'h14] = 8'd9;
    ctr_mem[8'h21] = 8'hFF;
    ctr_mem[8'h22] = 8'd0;
    ctr_mem[8'h26] = 8'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_cold_miss();
    t_read_hit_data_last();
    t_read_hit_pads_last();
    t_write_hit();
    t_evict();
    t_overflow();
    t_write_miss();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule